// File: doc/BRIEF.md
# Power Spectrum Integrating Accumulator

This block sits after a streaming FFT engine. Each cycle the engine may present one frequency bin as a signed in-phase and quadrature pair. A start-of-vector flag marks bin 0 of each spectrum. In power mode the block squares and sums the two parts of every bin and keeps a running total per bin in an internal memory. The total is built over a programmable number of consecutive spectra. While the last spectrum of each integration window streams in, every bin's finished total is sent out. A programmable right shift picks an 8-bit window of the total. When that window cannot hold the value, the output clamps at full scale.

In complex mode the block forwards the raw bins with the same latency. It does no squaring and no integration. An option holds back the first integration window by half a window, counted in spectra. Two units fed from one sample stream can then produce windows that overlap by half. The configuration inputs are sampled continuously and must be held stable between resets.

Top module: `pspec_integrator`

## Requirements
- R1: In power mode the per-bin term is I*I + Q*Q, with I and Q in two's complement. The first accepted spectrum of each window loads that term into the bin's total, and each later spectrum of the window adds to it.
- R2: With cfg_nint = N (1 to 262144, the value written directly), the window closes on every N-th counted spectrum. During that spectrum each bin produces one out_valid pulse, in bin order. The pulse appears on the second rising edge after the edge that captures the bin.
- R3: The per-bin total is 51 bits wide and never carries out, even with 262144 spectra at the largest input magnitudes.
- R4: out_power holds bits [cfg_shift+7 : cfg_shift] of the finished total. If any bit above cfg_shift+7 is set, out_power is 255. A shift of 51 or more gives 0.
- R5: With cfg_mode = 1 (complex), each accepted bin comes out two edges later on out_i and out_q, unchanged. out_power is 0 and no total is touched. With cfg_mode = 0, out_i and out_q are 0.
- R6: A valid bin with in_sov set is bin 0, and the bins that follow are numbered upward. out_bin gives that number, and out_eos marks bin cfg_nbins-1.
- R7: Valid bins that arrive before the first in_sov after reset are ignored. So are bins that follow bin cfg_nbins-1 before the next in_sov. Ignored bins produce no output and do not alter any total.
- R8: With cfg_half_dly = 1 in power mode, the first floor(N/2) complete spectra after reset are discarded. Windows then run back to back as normal.
- R9: cfg_nbins may be set anywhere from 1 to 256. With one bin per spectrum, back-to-back spectra still accumulate correctly.
- R10: While rst_n is low and after it rises, out_valid and out_eos are 0, and so are out_power, out_i, out_q and out_bin, until the first output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 1 | 0 power integration, 1 complex pass-through |
| cfg_nbins | input | 9 | Bins per spectrum, 1 to 256 |
| cfg_nint | input | 19 | Spectra per integration window, 1 to 262144 |
| cfg_shift | input | 6 | Right shift applied before the 8-bit field is taken |
| cfg_half_dly | input | 1 | Delay the first window by half a window |
| in_valid | input | 1 | Input bin present |
| in_sov | input | 1 | Input bin is bin 0 of a spectrum |
| in_i | input | 16 | In-phase part, signed |
| in_q | input | 16 | Quadrature part, signed |
| out_valid | output | 1 | Output bin present |
| out_eos | output | 1 | Output bin is the last of the spectrum |
| out_bin | output | 8 | Bin number of the output |
| out_power | output | 8 | Selected, saturated field of the integrated power |
| out_i | output | 16 | Passed-through in-phase part |
| out_q | output | 16 | Passed-through quadrature part |

## Verification
The hardest state to reach is the half-window offset combined with window boundaries. The discarded spectra must leave no trace, and the first real window must then load and not add. The bench reaches this state by resetting into each configuration. It then streams whole spectra while an independent arithmetic model tracks the skip count, the window index and the per-bin totals. A second hard case is a single-bin spectrum. There the same memory word is read on the cycle right after it is written. The bench sweeps it with back-to-back spectra and clamps the output with extreme samples.

// File: rtl/psi_pkg.sv
package psi_pkg;

   typedef enum logic {
      PSI_MODE_POWER   = 1'b0,
      PSI_MODE_COMPLEX = 1'b1
   } psi_mode_e;

   // Default geometry shared by the block and its checker
   localparam int unsigned PSI_SAMPLE_W = 16;
   localparam int unsigned PSI_MAX_BINS = 256;
   localparam int unsigned PSI_INT_LOG2 = 18;
   localparam int unsigned PSI_OUT_W    = 8;

endpackage

// File: rtl/psi_power.sv
module psi_power #(
   parameter int unsigned SAMPLE_W = 16,
   localparam int unsigned PROD_W  = 2 * SAMPLE_W,
   localparam int unsigned PWR_W   = PROD_W + 1
) (
   input  logic signed [SAMPLE_W-1:0] re,
   input  logic signed [SAMPLE_W-1:0] im,
   output logic        [PWR_W-1:0]    pwr
);

   logic signed [PROD_W-1:0] re_x;
   logic signed [PROD_W-1:0] im_x;
   logic signed [PROD_W-1:0] re_sq;
   logic signed [PROD_W-1:0] im_sq;

   always_comb begin
      re_x  = PROD_W'(re);
      im_x  = PROD_W'(im);
      re_sq = re_x * re_x;
      im_sq = im_x * im_x;
      pwr   = {1'b0, re_sq} + {1'b0, im_sq};
   end

endmodule

// File: rtl/psi_seq.sv
module psi_seq #(
   parameter int unsigned BIN_AW = 8,
   parameter int unsigned CNT_W  = 19
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sov,
   input  logic [BIN_AW:0]   cfg_nbins,
   input  logic [CNT_W-1:0]  cfg_nint,
   input  logic              cfg_half_dly,
   output logic              take,
   output logic [BIN_AW-1:0] bin,
   output logic              spec_end,
   output logic              use_spec,
   output logic              win_first,
   output logic              win_last
);

   logic              in_spec_q;
   logic [BIN_AW-1:0] bin_q;
   logic              started_q;
   logic [CNT_W-1:0]  skip_q;
   logic [CNT_W-1:0]  idx_q;
   logic [CNT_W-1:0]  eff_skip;
   logic [CNT_W-1:0]  skip_nxt;

   always_comb begin
      take      = in_valid && (in_sov || in_spec_q);
      bin       = in_sov ? '0 : bin_q + 1'b1;
      spec_end  = take && ({1'b0, bin} == cfg_nbins - 1'b1);
      if (started_q)         eff_skip = skip_q;
      else if (cfg_half_dly) eff_skip = cfg_nint >> 1;
      else                   eff_skip = '0;
      use_spec  = (eff_skip == '0);
      skip_nxt  = (spec_end && !use_spec) ? eff_skip - 1'b1 : eff_skip;
      win_first = (idx_q == '0);
      win_last  = (idx_q == cfg_nint - 1'b1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_spec_q <= 1'b0;
         bin_q     <= '0;
         started_q <= 1'b0;
         skip_q    <= '0;
         idx_q     <= '0;
      end else if (take) begin
         in_spec_q <= !spec_end;
         bin_q     <= bin;
         started_q <= 1'b1;
         skip_q    <= skip_nxt;
         if (spec_end && use_spec) idx_q <= win_last ? '0 : idx_q + 1'b1;
      end
   end

endmodule

// File: rtl/psi_accum_mem.sv
module psi_accum_mem #(
   parameter int unsigned DEPTH = 256,
   parameter int unsigned WIDTH = 51,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);

   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/psi_field_sel.sv
module psi_field_sel #(
   parameter int unsigned IN_W     = 51,
   parameter int unsigned OUT_W    = 8,
   parameter int unsigned SHIFT_W  = 6,
   parameter bit          SATURATE = 1'b1
) (
   input  logic [IN_W-1:0]    value,
   input  logic [SHIFT_W-1:0] shift,
   output logic [OUT_W-1:0]   field
);

   logic [IN_W-1:0] shifted;
   logic            too_big;

   always_comb begin
      shifted = value >> shift;
      too_big = |(shifted >> OUT_W);
   end

   if (SATURATE) begin : g_sat
      assign field = too_big ? '1 : shifted[OUT_W-1:0];
   end else begin : g_wrap
      assign field = shifted[OUT_W-1:0];
   end

endmodule

// File: rtl/pspec_integrator.sv
module pspec_integrator
   import psi_pkg::*;
#(
   parameter int unsigned SAMPLE_W = PSI_SAMPLE_W,
   parameter int unsigned MAX_BINS = PSI_MAX_BINS,
   parameter int unsigned INT_LOG2 = PSI_INT_LOG2,
   parameter int unsigned OUT_W    = PSI_OUT_W,
   parameter bit          SATURATE = 1'b1,
   localparam int unsigned BIN_AW  = $clog2(MAX_BINS),
   localparam int unsigned CNT_W   = INT_LOG2 + 1,
   localparam int unsigned PWR_W   = 2 * SAMPLE_W + 1,
   localparam int unsigned ACC_W   = PWR_W + INT_LOG2,
   localparam int unsigned SHIFT_W = $clog2(ACC_W)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_mode,
   input  logic [BIN_AW:0]            cfg_nbins,
   input  logic [CNT_W-1:0]           cfg_nint,
   input  logic [SHIFT_W-1:0]         cfg_shift,
   input  logic                       cfg_half_dly,
   input  logic                       in_valid,
   input  logic                       in_sov,
   input  logic signed [SAMPLE_W-1:0] in_i,
   input  logic signed [SAMPLE_W-1:0] in_q,
   output logic                       out_valid,
   output logic                       out_eos,
   output logic [BIN_AW-1:0]          out_bin,
   output logic [OUT_W-1:0]           out_power,
   output logic signed [SAMPLE_W-1:0] out_i,
   output logic signed [SAMPLE_W-1:0] out_q
);

   if (MAX_BINS < 2 || (1 << BIN_AW) != MAX_BINS) begin : g_bad_bins
      $error("MAX_BINS must be a power of two of at least 2");
   end
   if (OUT_W > ACC_W) begin : g_bad_out
      $error("OUT_W must not exceed the accumulator width");
   end

   psi_mode_e mode;
   assign mode = psi_mode_e'(cfg_mode);

   // Sequencing of bins and spectra
   logic              sq_take;
   logic [BIN_AW-1:0] sq_bin;
   logic              sq_end;
   logic              sq_use;
   logic              sq_first;
   logic              sq_last;

   psi_seq #(.BIN_AW(BIN_AW), .CNT_W(CNT_W)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .in_sov       (in_sov),
      .cfg_nbins    (cfg_nbins),
      .cfg_nint     (cfg_nint),
      .cfg_half_dly (cfg_half_dly),
      .take         (sq_take),
      .bin          (sq_bin),
      .spec_end     (sq_end),
      .use_spec     (sq_use),
      .win_first    (sq_first),
      .win_last     (sq_last)
   );

   // Stage A: captured bin and its window position
   logic                       a_valid;
   logic [BIN_AW-1:0]          a_bin;
   logic                       a_end;
   logic                       a_use;
   logic                       a_first;
   logic                       a_last;
   logic signed [SAMPLE_W-1:0] a_i;
   logic signed [SAMPLE_W-1:0] a_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_valid <= 1'b0;
         a_bin   <= '0;
         a_end   <= 1'b0;
         a_use   <= 1'b0;
         a_first <= 1'b0;
         a_last  <= 1'b0;
         a_i     <= '0;
         a_q     <= '0;
      end else begin
         a_valid <= sq_take;
         if (sq_take) begin
            a_bin   <= sq_bin;
            a_end   <= sq_end;
            a_use   <= sq_use;
            a_first <= sq_first;
            a_last  <= sq_last;
            a_i     <= in_i;
            a_q     <= in_q;
         end
      end
   end

   // Stage B: square, integrate, select
   logic [PWR_W-1:0] b_pwr;
   logic [ACC_W-1:0] b_old;
   logic [ACC_W:0]   b_sum;
   logic             b_we;
   logic             acc_carry;
   logic [OUT_W-1:0] b_field;

   psi_power #(.SAMPLE_W(SAMPLE_W)) u_power (
      .re  (a_i),
      .im  (a_q),
      .pwr (b_pwr)
   );

   psi_accum_mem #(.DEPTH(MAX_BINS), .WIDTH(ACC_W)) u_mem (
      .clk   (clk),
      .we    (b_we),
      .waddr (a_bin),
      .wdata (b_sum[ACC_W-1:0]),
      .raddr (a_bin),
      .rdata (b_old)
   );

   always_comb begin
      b_we      = a_valid && a_use && (mode == PSI_MODE_POWER);
      b_sum     = (a_first ? '0 : {1'b0, b_old}) + (ACC_W + 1)'(b_pwr);
      acc_carry = b_we && b_sum[ACC_W];
   end

   psi_field_sel #(
      .IN_W     (ACC_W),
      .OUT_W    (OUT_W),
      .SHIFT_W  (SHIFT_W),
      .SATURATE (SATURATE)
   ) u_field (
      .value (b_sum[ACC_W-1:0]),
      .shift (cfg_shift),
      .field (b_field)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_eos   <= 1'b0;
         out_bin   <= '0;
         out_power <= '0;
         out_i     <= '0;
         out_q     <= '0;
      end else if (mode == PSI_MODE_COMPLEX) begin
         out_valid <= a_valid;
         out_eos   <= a_valid && a_end;
         if (a_valid) begin
            out_bin   <= a_bin;
            out_power <= '0;
            out_i     <= a_i;
            out_q     <= a_q;
         end
      end else begin
         out_valid <= b_we && a_last;
         out_eos   <= b_we && a_last && a_end;
         out_i     <= '0;
         out_q     <= '0;
         if (b_we && a_last) begin
            out_bin   <= a_bin;
            out_power <= b_field;
         end
      end
   end

endmodule

// File: rtl/psi_checker.sv
module psi_checker #(
   parameter int unsigned SAMPLE_W = 16,
   parameter int unsigned BIN_AW   = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       cfg_mode,
   input logic [BIN_AW:0]            cfg_nbins,
   input logic                       in_valid,
   input logic                       in_sov,
   input logic signed [SAMPLE_W-1:0] in_i,
   input logic signed [SAMPLE_W-1:0] in_q,
   input logic                       out_valid,
   input logic                       out_eos,
   input logic [BIN_AW-1:0]          out_bin,
   input logic signed [SAMPLE_W-1:0] out_i,
   input logic signed [SAMPLE_W-1:0] out_q,
   input logic                       acc_carry
);

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_carry);

   assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid, 2));

   assert_eos_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_eos |-> out_valid);

   assert_eos_bin_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_eos |-> ({1'b0, out_bin} + 1'b1 == cfg_nbins));

   assert_first_bin_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(in_valid && in_sov, 2)) |-> (out_bin == '0));

   assert_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && cfg_mode) |-> (out_i == $past(in_i, 2) && out_q == $past(in_q, 2)));

endmodule

bind pspec_integrator psi_checker #(.SAMPLE_W(SAMPLE_W), .BIN_AW(BIN_AW)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_mode  (cfg_mode),
   .cfg_nbins (cfg_nbins),
   .in_valid  (in_valid),
   .in_sov    (in_sov),
   .in_i      (in_i),
   .in_q      (in_q),
   .out_valid (out_valid),
   .out_eos   (out_eos),
   .out_bin   (out_bin),
   .out_i     (out_i),
   .out_q     (out_q),
   .acc_carry (acc_carry)
);

// File: tb/test_pspec_integrator.sv
module test_pspec_integrator;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_mode = 1'b0;
   logic [8:0]        cfg_nbins = 9'd4;
   logic [18:0]       cfg_nint = 19'd1;
   logic [5:0]        cfg_shift = 6'd0;
   logic              cfg_half_dly = 1'b0;
   logic              in_valid = 1'b0;
   logic              in_sov = 1'b0;
   logic signed [15:0] in_i = '0;
   logic signed [15:0] in_q = '0;
   logic              out_valid;
   logic              out_eos;
   logic [7:0]        out_bin;
   logic [7:0]        out_power;
   logic signed [15:0] out_i;
   logic signed [15:0] out_q;

   always #2 clk = ~clk;

   pspec_integrator i_pspec_integrator (
      .clk (clk), .rst_n (rst_n), .cfg_mode (cfg_mode), .cfg_nbins (cfg_nbins),
      .cfg_nint (cfg_nint), .cfg_shift (cfg_shift), .cfg_half_dly (cfg_half_dly),
      .in_valid (in_valid), .in_sov (in_sov), .in_i (in_i), .in_q (in_q),
      .out_valid (out_valid), .out_eos (out_eos), .out_bin (out_bin),
      .out_power (out_power), .out_i (out_i), .out_q (out_q)
   );

   typedef struct {
      bit    cplx;
      int    pw;
      int    ei;
      int    eq;
      int    bin;
      bit    eos;
      string tag;
   } exp_t;

   exp_t  expq[$];
   int    checks = 0;
   int    fails = 0;
   bit    finished = 0;

   // Model state, from the requirements
   longint acc_m [256];
   bit     m_started;
   bit     m_in_spec;
   int     m_skip;
   int     m_idx;
   int     m_bin;

   function automatic int field_of(longint v, int sh);
      longint s;
      if (sh >= 51) return 0;
      s = v >>> sh;
      return (s > 255) ? 255 : int'(s);
   endfunction

   task automatic report;
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   // Output monitor
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         checks++;
         if (expq.size() == 0) begin
            fails++;
            $display("FAIL R7: unexpected output bin=%0d power=%0d, expected none", out_bin, out_power);
         end else begin
            exp_t e;
            e = expq.pop_front();
            if (e.cplx) begin
               if ($signed(out_i) != e.ei || $signed(out_q) != e.eq || int'(out_bin) != e.bin ||
                   out_eos != e.eos || out_power != 8'd0) begin
                  fails++;
                  $display("FAIL %s: bin=%0d i=%0d q=%0d eos=%0d pw=%0d, expected bin=%0d i=%0d q=%0d eos=%0d pw=0",
                           e.tag, out_bin, out_i, out_q, out_eos, out_power, e.bin, e.ei, e.eq, e.eos);
               end
            end else begin
               if (int'(out_power) != e.pw || int'(out_bin) != e.bin || out_eos != e.eos ||
                   out_i != 16'sd0 || out_q != 16'sd0) begin
                  fails++;
                  $display("FAIL %s: bin=%0d power=%0d eos=%0d, expected bin=%0d power=%0d eos=%0d",
                           e.tag, out_bin, out_power, out_eos, e.bin, e.pw, e.eos);
               end
            end
         end
      end
   end

   task automatic do_reset(bit mode, int nb, int ni, int sh, bit half);
      @(negedge clk);
      rst_n = 1'b0;
      in_valid = 1'b0;
      in_sov = 1'b0;
      cfg_mode = mode;
      cfg_nbins = 9'(nb);
      cfg_nint = 19'(ni);
      cfg_shift = 6'(sh);
      cfg_half_dly = half;
      m_started = 0; m_in_spec = 0; m_skip = 0; m_idx = 0; m_bin = 0;
      repeat (3) @(negedge clk);
      checks++;
      if (out_valid || out_eos || out_power != 0 || out_i != 0 || out_q != 0 || out_bin != 0) begin
         fails++;
         $display("FAIL R10: during reset valid=%0d eos=%0d pw=%0d bin=%0d, expected all 0",
                  out_valid, out_eos, out_power, out_bin);
      end
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic idle(int n);
      in_valid = 1'b0;
      in_sov = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic send(bit sov, int vi, int vq, string tag);
      int  b, eff, nb, ni;
      bit  endb;
      exp_t e;
      nb = int'(cfg_nbins);
      ni = int'(cfg_nint);
      if (sov || m_in_spec) begin
         b = sov ? 0 : m_bin + 1;
         endb = (b == nb - 1);
         eff = m_started ? m_skip : (cfg_half_dly ? ni / 2 : 0);
         if (cfg_mode) begin
            e.cplx = 1; e.pw = 0; e.ei = vi; e.eq = vq; e.bin = b; e.eos = endb; e.tag = tag;
            expq.push_back(e);
         end else if (eff == 0) begin
            longint p;
            p = longint'(vi) * vi + longint'(vq) * vq;
            acc_m[b] = (m_idx == 0) ? p : acc_m[b] + p;
            if (m_idx == ni - 1) begin
               e.cplx = 0; e.pw = field_of(acc_m[b], int'(cfg_shift));
               e.ei = 0; e.eq = 0; e.bin = b; e.eos = endb; e.tag = tag;
               expq.push_back(e);
            end
            if (endb) m_idx = (m_idx == ni - 1) ? 0 : m_idx + 1;
         end
         m_started = 1;
         m_skip = (endb && eff != 0) ? eff - 1 : eff;
         m_in_spec = !endb;
         m_bin = b;
      end
      in_valid = 1'b1;
      in_sov = sov;
      in_i = 16'(vi);
      in_q = 16'(vq);
      @(negedge clk);
   endtask

   function automatic int sample(int s, int b, int k);
      int v;
      v = ((s * 7919 + b * 1543 + k * 40503 + 17) % 65536) - 32768;
      if ((b + s) % 5 == 0 && k == 0) v = -32768;
      if ((b + s) % 7 == 1 && k == 1) v = 32767;
      return v;
   endfunction

   task automatic spectrum(int s, int nb, int scale, string tag);
      for (int b = 0; b < nb; b++)
         send(b == 0, sample(s, b, 0) / scale, sample(s, b, 1) / scale, tag);
   endtask

   task automatic drain(string tag);
      idle(4);
      checks++;
      if (expq.size() != 0) begin
         fails++;
         $display("FAIL %s: %0d outputs missing, expected 0", tag, expq.size());
         expq.delete();
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      report();
   end

   initial begin
      // R1 R4 R10: single-spectrum windows over a sweep of shifts
      for (int sh = 0; sh < 64; sh += 7) begin
         do_reset(1'b0, 4, 1, sh, 1'b0);
         spectrum(sh, 4, 1, "R4");
         spectrum(sh + 1, 4, 181, "R1");
         drain("R4");
      end
      // R1 R2: integration of three spectra, two windows, with gaps
      for (int sh = 8; sh <= 34; sh += 13) begin
         do_reset(1'b0, 4, 3, sh, 1'b0);
         for (int s = 0; s < 6; s++) begin
            spectrum(s, 4, (s % 2) ? 1 : 97, "R2");
            idle(s % 3);
         end
         drain("R2");
      end
      // R9: one bin per spectrum, back to back
      for (int ni = 1; ni <= 4; ni++) begin
         do_reset(1'b0, 1, ni, 24, 1'b0);
         for (int s = 0; s < 3 * ni; s++) spectrum(s, 1, 1, "R9");
         drain("R9");
      end
      // R8: half-window offset for several window lengths
      for (int ni = 1; ni <= 5; ni++) begin
         do_reset(1'b0, 3, ni, 20, 1'b1);
         for (int s = 0; s < ni / 2 + 2 * ni; s++) spectrum(s + 3, 3, 1, "R8");
         drain("R8");
      end
      // R7: stray bins before sov and past the last bin
      do_reset(1'b0, 3, 2, 4, 1'b0);
      for (int k = 0; k < 3; k++) send(1'b0, 30000, -30000, "R7");
      spectrum(9, 3, 200, "R7");
      for (int k = 0; k < 2; k++) send(1'b0, -32768, -32768, "R7");
      idle(2);
      spectrum(10, 3, 200, "R7");
      drain("R7");
      // R5: complex pass-through, including ignored bins
      do_reset(1'b1, 5, 3, 0, 1'b1);
      send(1'b0, 11, 22, "R5");
      for (int s = 0; s < 3; s++) spectrum(s, 5, 1, "R5");
      send(1'b0, 33, 44, "R5");
      drain("R5");
      // R6 R2: full-length spectra
      do_reset(1'b0, 256, 2, 16, 1'b0);
      for (int s = 0; s < 2; s++) spectrum(s, 256, 1, "R6");
      drain("R6");
      // R3: extreme samples held in every bin, largest products
      do_reset(1'b0, 2, 8, 40, 1'b0);
      for (int s = 0; s < 8; s++) begin
         send(1'b1, -32768, -32768, "R3");
         send(1'b0, -32768, 32767, "R3");
      end
      drain("R3");
      report();
   end

endmodule